// File: doc/BRIEF.md
# Read Resynchronization Phase Calibrator

This block calibrates the read path of a source-synchronous memory interface once, straight after reset and before any normal traffic. It walks the phase of a resynchronization clock around a full cycle in 24 steps of 15 degrees. For each step it asks a reconfigurable clock source to move to that phase and waits for the source to acknowledge. It then requests one read of a fixed training burst and compares every captured beat, pin by pin, with the pattern it holds internally. The outcome of each step is stored as one pass or fail bit.

When the last step has been tried, the block finds the longest run of adjacent passing phases. The search wraps from the last phase back to phase 0, so a passing window that straddles the wrap point is treated as one window. The block picks the middle of that run, because that phase gives the most setup and hold margin. It sends one final phase request so the clock source settles on the chosen phase, and then raises done. If no phase passes, it raises a fail flag, moves to phase 0, and still signals done. The surrounding controller holds off normal reads until done is high.

Top module: `rsync_phase_cal`

## Requirements
- R1: After reset the block requests phase indices 0, 1, …, 23 in that order, one index per step of 15 degrees. Each request holds `phase_req` high with a steady `phase_sel` until `phase_ack` is seen.
- R2: Exactly one read is issued per phase step. The read is a single-cycle `rd_req`, raised in the cycle after the acknowledge is taken. It is never raised while a phase request is pending.
- R3: The training burst has four beats, each taken on a cycle with `rd_valid` high. Even beats (0 and 2) are expected to be 0x55, meaning bit k is 1 when k is even. Odd beats (1 and 3) are expected to be 0xAA.
- R4: A pin passes at a phase only if its bit matches on all four beats. A phase passes only if all 8 pins pass, so a single wrong bit on one beat fails the whole phase.
- R5: The chosen phase is (s + (L-1)/2) mod 24, where L is the length of the longest run of consecutive passing phases and s is that run's first index. Runs may wrap from 23 to 0. If two runs have the same length, the one found first wins. The search scans indices 0..23 and then continues around once more, so a run that does not wrap beats a wrapping run of equal length.
- R6: If all 24 phases pass, the chosen phase is 11.
- R7: If no phase passes, `cal_fail` goes high, `best_phase` is 0, and `cal_done` is still raised.
- R8: After the sweep, one more phase request carries the chosen phase (0 on failure). `cal_done` rises in the cycle after that acknowledge. From then on `cal_done`, `cal_fail` and `best_phase` hold steady until reset.
- R9: While reset is low, `phase_req`, `rd_req`, `cal_done` and `cal_fail` are all low.
- R10: `rd_valid` has no effect when the block is not collecting a burst. `phase_ack` has no effect when no phase request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; calibration starts when released |
| phase_ack | input | 1 | Clock source has reached the requested phase |
| rd_valid | input | 1 | A captured beat is present on `rd_data` |
| rd_data | input | 8 | Captured DQ bits of one beat, one bit per pin |
| phase_req | output | 1 | Request to move the resynchronization clock |
| phase_sel | output | 5 | Requested phase index (x15 degrees) |
| rd_req | output | 1 | Single-cycle request for one training read |
| best_phase | output | 5 | Chosen phase index |
| cal_done | output | 1 | Calibration finished |
| cal_fail | output | 1 | No passing phase was found |

## Verification
Some rules can be checked on every cycle, and the assertions do so. A pending phase request keeps its index steady until acknowledged. A read pulse lasts one cycle and never overlaps a phase request. The phase index stays within range. Done, fail and the chosen phase stay frozen once done is high, and a failed calibration reports phase 0.

Other behaviour can only be shown through whole sweeps, so the bench runs them. These cover the sweep order, the comparison against the training burst, and the choice of window centre. The sweeps include a window that straddles the wrap point, a tie between equal windows, a single passing phase, all-pass and all-fail maps, and stray valid and acknowledge pulses.

// File: rtl/rsync_phase_cal.sv
module rsync_phase_cal #(
  parameter int NPIN   = 8,
  parameter int NPHASE = 24,
  parameter int BEATS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      phase_ack,
  input  logic                      rd_valid,
  input  logic [NPIN-1:0]           rd_data,
  output logic                      phase_req,
  output logic [$clog2(NPHASE)-1:0] phase_sel,
  output logic                      rd_req,
  output logic [$clog2(NPHASE)-1:0] best_phase,
  output logic                      cal_done,
  output logic                      cal_fail
);
  localparam int IW = $clog2(NPHASE);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STEP, ST_RD, ST_CAP, ST_FIN, ST_APPLY, ST_DONE
  } st_t;

  st_t              st;
  logic [IW-1:0]    idx;
  logic [BW-1:0]    beat;
  logic [NPIN-1:0]  bad;
  logic [NPIN-1:0]  bad_n;
  logic [NPHASE-1:0] pass_map;
  logic [IW-1:0]    win_mid;
  logic [IW:0]      win_len;

  function automatic logic [NPIN-1:0] train(input logic odd);
    logic [NPIN-1:0] v;
    for (int k = 0; k < NPIN; k++) v[k] = ((k % 2) == 0) ^ odd;
    return v;
  endfunction

  assign bad_n     = bad | (rd_data ^ train(beat[0]));
  assign phase_req = (st == ST_STEP) || (st == ST_APPLY);
  assign rd_req    = (st == ST_RD);
  assign cal_done  = (st == ST_DONE);
  assign phase_sel = (st == ST_APPLY || st == ST_DONE) ? best_phase : idx;

  always_comb begin
    int run, bl, bs;
    run = 0; bl = 0; bs = 0;
    for (int i = 0; i < 2 * NPHASE; i++) begin
      if (pass_map[i % NPHASE]) begin
        if (run < NPHASE) run = run + 1;
        if (run > bl) begin
          bl = run;
          bs = (i - run + 1) % NPHASE;
        end
      end else begin
        run = 0;
      end
    end
    win_len = (IW+1)'(bl);
    win_mid = (bl == 0) ? '0 : IW'((bs + (bl - 1) / 2) % NPHASE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      idx        <= '0;
      beat       <= '0;
      bad        <= '0;
      pass_map   <= '0;
      best_phase <= '0;
      cal_fail   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE:  st <= ST_STEP;
        ST_STEP:  if (phase_ack) st <= ST_RD;
        ST_RD: begin
          beat <= '0;
          bad  <= '0;
          st   <= ST_CAP;
        end
        ST_CAP: if (rd_valid) begin
          bad  <= bad_n;
          beat <= beat + 1'b1;
          if (beat == BW'(BEATS - 1)) begin
            pass_map[idx] <= ~|bad_n;
            if (idx == IW'(NPHASE - 1)) begin
              st <= ST_FIN;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_STEP;
            end
          end
        end
        ST_FIN: begin
          best_phase <= win_mid;
          cal_fail   <= (win_len == '0);
          st         <= ST_APPLY;
        end
        ST_APPLY: if (phase_ack) st <= ST_DONE;
        default:  st <= ST_DONE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    phase_req && !phase_ack |=> phase_req && $stable(phase_sel)); // R1
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_sel < IW'(NPHASE)); // R1
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R2
  AST_RD_NOT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    phase_req |-> !rd_req); // R2
  AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cal_fail |-> best_phase == '0); // R7
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done) |-> $past(phase_ack)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> cal_done && $stable(best_phase) && $stable(cal_fail)); // R8
endmodule

// File: tb/tb_rsync_phase_cal.sv
module tb_rsync_phase_cal;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_ack = 1'b0;
  logic       rd_valid = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic       phase_req, rd_req, cal_done, cal_fail;
  logic [4:0] phase_sel, best_phase;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  rsync_phase_cal dut (
    .clk(clk), .rst_n(rst_n), .phase_ack(phase_ack), .rd_valid(rd_valid),
    .rd_data(rd_data), .phase_req(phase_req), .phase_sel(phase_sel),
    .rd_req(rd_req), .best_phase(best_phase), .cal_done(cal_done),
    .cal_fail(cal_fail)
  );

  always #5 clk = ~clk;

  localparam int NV = 9;
  localparam logic [23:0] MASKS [NV] = '{
    24'hFFFFFF, 24'h000000, 24'h0003E0, 24'hF01C07, 24'hC0003F,
    24'h01C01C, 24'h020000, 24'h003F00, 24'hFFFFBF
  };
  localparam logic [4:0] BESTS [NV] = '{
    5'd11, 5'd0, 5'd7, 5'd23, 5'd1, 5'd3, 5'd17, 5'd10, 5'd18
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int b);
    return (b % 2 == 0) ? 8'h55 : 8'hAA;
  endfunction

  task automatic run_cal(input logic [23:0] mask, input logic [4:0] exp_best, input bit stray);
    logic [4:0] held;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 24; p++) begin
      do @(negedge clk); while (!phase_req);
      chk(phase_sel == 5'(p), "R1 sweep order", phase_sel, p);
      for (int d = 0; d < p % 3; d++) begin
        if (stray) begin rd_valid = 1'b1; rd_data = 8'h00; end
        @(negedge clk);
        rd_valid = 1'b0;
        chk(phase_req && phase_sel == 5'(p), "R1 request held", phase_sel, p);
        chk(!rd_req, "R2 no read before ack", rd_req, 0);
      end
      phase_ack = 1'b1;
      @(negedge clk);
      phase_ack = 1'b0;
      chk(rd_req, "R2 read after ack", rd_req, 1);
      @(negedge clk);
      chk(!rd_req, "R2 single-cycle read", rd_req, 0);
      for (int b = 0; b < 4; b++) begin
        if ((p % 2) == 1 && b == 2) begin
          rd_valid = 1'b0;
          if (stray) phase_ack = 1'b1;
          @(negedge clk);
          phase_ack = 1'b0;
        end
        rd_valid = 1'b1;
        rd_data = pat(b);
        if (!mask[p] && b == p % 4) rd_data[p % 8] = ~rd_data[p % 8];
        @(negedge clk);
      end
      rd_valid = 1'b0;
    end
    do @(negedge clk); while (!phase_req);
    chk(phase_sel == exp_best, "R8 final phase request", phase_sel, exp_best);
    chk(!cal_done, "R8 done waits for ack", cal_done, 0);
    phase_ack = 1'b1;
    @(negedge clk);
    phase_ack = 1'b0;
    chk(cal_done, "R8 done after ack", cal_done, 1);
    chk(best_phase == exp_best, "R4 R5 chosen centre", best_phase, exp_best);
    chk(cal_fail == (mask == 24'h0), "R4 fail flag", cal_fail, mask == 24'h0);
    if (mask == 24'hFFFFFF) begin
      chk(best_phase == 5'd11, "R6 all pass centre", best_phase, 11);
      chk(!cal_fail, "R3 training pattern accepted", cal_fail, 0);
    end
    if (mask == 24'h0) begin
      chk(cal_fail && best_phase == 5'd0, "R7 no pass", best_phase, 0);
    end
    held = best_phase;
    for (int k = 0; k < 4; k++) begin
      phase_ack = 1'b1; rd_valid = 1'b1; rd_data = 8'hFF;
      @(negedge clk);
    end
    phase_ack = 1'b0; rd_valid = 1'b0;
    @(negedge clk);
    chk(cal_done && best_phase == held && !phase_req && !rd_req,
        "R10 stray inputs after done", best_phase, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!phase_req && !rd_req, "R9 reset requests", {phase_req, rd_req}, 0);
    chk(!cal_done && !cal_fail, "R9 reset flags", {cal_done, cal_fail}, 0);
    for (int v = 0; v < NV; v++) run_cal(MASKS[v], BESTS[v], v == 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!cal_done && !phase_req, "R9 reset after done", cal_done, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule